// File: doc/BRIEF.md
# Parser Node Next-Header Decision

This block is the successor-selection logic of a single node in a streaming packet-header parser. The packet arrives as a stream of bus beats, each with start-of-packet, end-of-packet and packet-identifier metadata. The previous pipeline stage supplies a header code that names the header now under analysis. The node acts only when that code equals its own fixed identity. Beats that carry any other code pass it by and leave its state unchanged.

A bit counter runs inside the node. It finds the beat whose window contains the node's key field: the field that names the protocol carried next. The node shifts that beat down by the key's lane offset and masks it to the key width. It then compares the aligned key, in the same cycle, against a small successor table that is fixed at elaboration. The registered result is one of two things. A hit gives a next-header code with a valid flag. A miss gives a header-exception flag. The result stays up until the packet's last beat.

Header bit 0 is bit 0 of the first beat of the packet. Successive beats carry higher header bits. The key must lie within a single beat.

Top module: `nhs_transition`

## Requirements
- R1: After reset, `nh_valid`, `hdr_exc`, `nh_code` and `nh_pkt_id` are all zero.
- R2: A beat counts as accepted only when `beat_valid` is high and `hdr_code_in` equals `NODE_ID`. A beat that is not accepted changes nothing: the outputs hold, and the bit counter does not advance.
- R3: The bit counter restarts at zero on an accepted start-of-packet beat and advances by `BUS_W` on each accepted beat. The key window is the accepted beat whose starting bit count equals `(KEY_OFF / BUS_W) * BUS_W`. The key is evaluated once per packet.
- R4: The key is bits `[KEY_OFF % BUS_W +: KEY_W]` of the key-window beat, obtained by shift and mask. No other bit of any beat affects the result.
- R5: A key that equals entry i of `KEY_TABLE` (packed at `[i*KEY_W +: KEY_W]`) gives, one clock after the key beat, `nh_valid`=1, `hdr_exc`=0 and `nh_code` = `CODE_TABLE[i*CODE_W +: CODE_W]`.
- R6: A key that matches no entry gives, one clock after the key beat, `hdr_exc`=1, `nh_valid`=0 and `nh_code`=0.
- R7: When several entries hold the same key, the entry with the lowest index supplies the code.
- R8: The result holds until an accepted end-of-packet or start-of-packet beat that is not the key window. One clock after that beat, `nh_valid`, `hdr_exc`, `nh_code` and `nh_pkt_id` are zero.
- R9: `nh_pkt_id` carries the `beat_pkt_id` of the key beat for as long as the result is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | Beat present on the bus |
| beat_sop | input | 1 | Beat is the first of a packet |
| beat_eop | input | 1 | Beat is the last of a packet |
| beat_pkt_id | input | PID_W | Packet identifier of the beat |
| beat_data | input | BUS_W | Beat payload |
| hdr_code_in | input | CODE_W | Header code assigned by the previous stage |
| nh_valid | output | 1 | Successor found |
| hdr_exc | output | 1 | Key matched no table entry |
| nh_code | output | CODE_W | Successor header code |
| nh_pkt_id | output | PID_W | Packet identifier attached to the result |

## Verification
A counter that is off by one beat shows up one clock after the intended key beat. The result then comes from the wrong lane of data, so a known key reads as an exception or as a different successor code. A stuck identity gate shows up at the ports in two ways: a foreign-coded beat carrying a key moves the result, or it shifts the window so that the next matching beat is taken as a non-key beat. A stuck result register shows up one clock after the end-of-packet beat, when the flags should clear and do not.

// File: rtl/nhs_pkg.sv
package nhs_pkg;
    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } res_kind_e;
endpackage

// File: rtl/nhs_key_align.sv
// Moves the key lane of a beat down to bit 0 and clears everything above it.
module nhs_key_align #(
    parameter int BUS_W   = 32,
    parameter int KEY_OFF = 40,
    parameter int KEY_W   = 8
) (
    input  logic [BUS_W-1:0] data_i,
    output logic [BUS_W-1:0] key_o
);
    localparam int LANE = KEY_OFF % BUS_W;
    localparam logic [BUS_W-1:0] MASK = ~({BUS_W{1'b1}} << KEY_W);

    logic [BUS_W-1:0] shifted;

    assign shifted = data_i >> LANE;
    assign key_o   = shifted & MASK;
endmodule

// File: rtl/nhs_succ_match.sv
// Compares the aligned key with every table entry in parallel. The lowest index wins.
module nhs_succ_match #(
    parameter int BUS_W  = 32,
    parameter int KEY_W  = 8,
    parameter int CODE_W = 4,
    parameter int N_ENT  = 4,
    parameter logic [N_ENT*KEY_W-1:0]  KEY_TABLE  = '0,
    parameter logic [N_ENT*CODE_W-1:0] CODE_TABLE = '0
) (
    input  logic [BUS_W-1:0]  key_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] code_o
);
    logic [N_ENT-1:0] ent_hit;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        assign ent_hit[gi] = (key_i == BUS_W'(KEY_TABLE[gi*KEY_W +: KEY_W]));
    end

    always_comb begin
        hit_o  = 1'b0;
        code_o = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (ent_hit[i]) begin
                hit_o  = 1'b1;
                code_o = CODE_TABLE[i*CODE_W +: CODE_W];
            end
        end
    end
endmodule

// File: rtl/nhs_transition.sv
module nhs_transition #(
    parameter int BUS_W   = 32,
    parameter int KEY_OFF = 40,
    parameter int KEY_W   = 8,
    parameter int CODE_W  = 4,
    parameter int PID_W   = 8,
    parameter logic [CODE_W-1:0] NODE_ID = 4'd3,
    parameter int N_ENT   = 4,
    parameter logic [N_ENT*KEY_W-1:0]  KEY_TABLE  = 32'h2233_2211,
    parameter logic [N_ENT*CODE_W-1:0] CODE_TABLE = 16'h9765
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic              beat_sop,
    input  logic              beat_eop,
    input  logic [PID_W-1:0]  beat_pkt_id,
    input  logic [BUS_W-1:0]  beat_data,
    input  logic [CODE_W-1:0] hdr_code_in,
    output logic              nh_valid,
    output logic              hdr_exc,
    output logic [CODE_W-1:0] nh_code,
    output logic [PID_W-1:0]  nh_pkt_id
);
    import nhs_pkg::*;

    localparam int KEY_WIN   = KEY_OFF / BUS_W;
    localparam int KEY_START = KEY_WIN * BUS_W;
    localparam int CNT_W     = $clog2(KEY_START + BUS_W + 1) + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  rcv_bits;
        res_kind_e         kind;
        logic [CODE_W-1:0] code;
        logic [PID_W-1:0]  pid;
    } st_t;

    st_t st_d, st_q;

    logic              hdr_valid;
    logic              take;
    logic              key_win;
    logic [CNT_W-1:0]  win_start;
    logic [BUS_W-1:0]  aligned_key;
    logic              tbl_hit;
    logic [CODE_W-1:0] tbl_code;

    nhs_key_align #(
        .BUS_W  (BUS_W),
        .KEY_OFF(KEY_OFF),
        .KEY_W  (KEY_W)
    ) u_align (
        .data_i(beat_data),
        .key_o (aligned_key)
    );

    nhs_succ_match #(
        .BUS_W     (BUS_W),
        .KEY_W     (KEY_W),
        .CODE_W    (CODE_W),
        .N_ENT     (N_ENT),
        .KEY_TABLE (KEY_TABLE),
        .CODE_TABLE(CODE_TABLE)
    ) u_match (
        .key_i (aligned_key),
        .hit_o (tbl_hit),
        .code_o(tbl_code)
    );

    always_comb begin
        hdr_valid = (hdr_code_in == NODE_ID);
        take      = beat_valid & hdr_valid;
        win_start = beat_sop ? '0 : st_q.rcv_bits;
        key_win   = (win_start == CNT_W'(KEY_START));

        st_d = st_q;
        if (take) begin
            // Stop counting once past the key window so the count cannot wrap into it again.
            if (win_start <= CNT_W'(KEY_START)) begin
                st_d.rcv_bits = win_start + CNT_W'(BUS_W);
            end else begin
                st_d.rcv_bits = win_start;
            end

            if (key_win) begin
                st_d.kind = tbl_hit ? RES_HIT : RES_MISS;
                st_d.code = tbl_hit ? tbl_code : '0;
                st_d.pid  = beat_pkt_id;
            end else if (beat_eop || beat_sop) begin
                st_d.kind = RES_IDLE;
                st_d.code = '0;
                st_d.pid  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rcv_bits: '0, kind: RES_IDLE, code: '0, pid: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nh_valid  = (st_q.kind == RES_HIT);
    assign hdr_exc   = (st_q.kind == RES_MISS);
    assign nh_code   = st_q.code;
    assign nh_pkt_id = st_q.pid;
endmodule

// File: rtl/nhs_transition_chk.sv
module nhs_transition_chk #(
    parameter int CODE_W = 4,
    parameter int PID_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take,
    input logic              key_win,
    input logic              beat_sop,
    input logic              beat_eop,
    input logic              nh_valid,
    input logic              hdr_exc,
    input logic [CODE_W-1:0] nh_code,
    input logic [PID_W-1:0]  nh_pkt_id
);
    // R2: a beat that is not accepted leaves the result untouched
    p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(nh_valid) && $stable(hdr_exc) && $stable(nh_code) && $stable(nh_pkt_id)));

    // R5: a successor only appears right after an accepted key beat
    p_hit_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nh_valid) |-> $past(take && key_win));

    // R6: an exception only appears right after an accepted key beat, with a zero code
    p_exc_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_exc) |-> $past(take && key_win));

    p_exc_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_exc |-> (nh_code == '0));

    // R8: a packet boundary outside the key window clears the result
    p_boundary_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !key_win && (beat_eop || beat_sop)) |=> (!nh_valid && !hdr_exc && nh_pkt_id == '0));

    // R9: with no result shown, the code and packet id stay zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!nh_valid && !hdr_exc) |-> (nh_code == '0 && nh_pkt_id == '0));
endmodule

bind nhs_transition nhs_transition_chk #(
    .CODE_W(CODE_W),
    .PID_W (PID_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .key_win  (key_win),
    .beat_sop (beat_sop),
    .beat_eop (beat_eop),
    .nh_valid (nh_valid),
    .hdr_exc  (hdr_exc),
    .nh_code  (nh_code),
    .nh_pkt_id(nh_pkt_id)
);

// File: tb/sim_nhs_transition.sv
`timescale 1ns/1ps
module sim_nhs_transition;
    localparam logic [3:0] ME    = 4'd3;
    localparam logic [3:0] OTHER = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_valid = 1'b0;
    logic        beat_sop = 1'b0;
    logic        beat_eop = 1'b0;
    logic [7:0]  beat_pkt_id = '0;
    logic [31:0] beat_data = '0;
    logic [3:0]  hdr_code_in = '0;
    logic        nh_valid;
    logic        hdr_exc;
    logic [3:0]  nh_code;
    logic [7:0]  nh_pkt_id;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    nhs_transition u0 (
        .clk(clk), .rst_n(rst_n),
        .beat_valid(beat_valid), .beat_sop(beat_sop), .beat_eop(beat_eop),
        .beat_pkt_id(beat_pkt_id), .beat_data(beat_data), .hdr_code_in(hdr_code_in),
        .nh_valid(nh_valid), .hdr_exc(hdr_exc), .nh_code(nh_code), .nh_pkt_id(nh_pkt_id)
    );

    // Successor table as the requirements give it: keys 11,22,33,22 -> codes 5,6,7,9
    function automatic void lookup(input logic [7:0] k, output logic hit, output logic [3:0] code);
        logic [7:0] keys [4] = '{8'h11, 8'h22, 8'h33, 8'h22};
        logic [3:0] codes [4] = '{4'd5, 4'd6, 4'd7, 4'd9};
        hit = 1'b0;
        code = 4'd0;
        for (int i = 3; i >= 0; i--) begin
            if (keys[i] == k) begin
                hit = 1'b1;
                code = codes[i];
            end
        end
    endfunction

    // Key lane is bits [15:8] of the second beat (offset 40, bus 32)
    function automatic logic [31:0] with_key(input logic [7:0] k, input logic [7:0] noise);
        return {noise ^ 8'hC3, noise, k, ~noise};
    endfunction

    task automatic beat(input logic [3:0] code, input logic sop, input logic eop,
                        input logic [7:0] pid, input logic [31:0] data);
        beat_valid = 1'b1; hdr_code_in = code; beat_sop = sop; beat_eop = eop;
        beat_pkt_id = pid; beat_data = data;
        @(posedge clk); #1;
        beat_valid = 1'b0; beat_sop = 1'b0; beat_eop = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic ev, input logic ex,
                              input logic [3:0] ec, input logic [7:0] ep);
        total++;
        if (nh_valid !== ev || hdr_exc !== ex || nh_code !== ec || nh_pkt_id !== ep) begin
            bad++;
            $display("FAIL %s: got v=%0b x=%0b code=%0d pid=%0d, want v=%0b x=%0b code=%0d pid=%0d",
                     req, nh_valid, hdr_exc, nh_code, nh_pkt_id, ev, ex, ec, ep);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got hung run, want completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic hit;
        logic [3:0] code;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 reset", 1'b0, 1'b0, 4'd0, 8'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        expect_out("R1 after reset", 1'b0, 1'b0, 4'd0, 8'd0);

        // R4 R5 R6 R7 R9 R8: sweep every key value with varying surrounding bits
        for (int k = 0; k < 256; k++) begin
            lookup(8'(k), hit, code);
            beat(ME, 1'b1, 1'b0, 8'(k), with_key(8'h22, 8'(k * 7)));
            beat(ME, 1'b0, 1'b0, 8'(k + 1), with_key(8'(k), 8'(k * 13 + 5)));
            expect_out(hit ? "R5 R7 R9 hit" : "R6 R4 miss", hit, !hit, code, 8'(k + 1));
            beat(ME, 1'b0, 1'b1, 8'(k + 1), with_key(8'h11, 8'(k)));
            expect_out("R8 eop clear", 1'b0, 1'b0, 4'd0, 8'd0);
        end

        // R2 R3: foreign beats neither count nor touch outputs
        beat(ME, 1'b1, 1'b0, 8'd40, 32'h0);
        beat(OTHER, 1'b0, 1'b0, 8'd41, with_key(8'h11, 8'h00));
        expect_out("R2 foreign key beat ignored", 1'b0, 1'b0, 4'd0, 8'd0);
        beat(ME, 1'b0, 1'b0, 8'd42, with_key(8'h33, 8'h10));
        expect_out("R2 R3 counter held over foreign beat", 1'b1, 1'b0, 4'd7, 8'd42);
        beat(OTHER, 1'b0, 1'b1, 8'd43, 32'h0);
        expect_out("R2 foreign eop ignored", 1'b1, 1'b0, 4'd7, 8'd42);
        beat(OTHER, 1'b1, 1'b0, 8'd44, 32'h0);
        expect_out("R2 foreign sop ignored", 1'b1, 1'b0, 4'd7, 8'd42);
        beat(ME, 1'b0, 1'b1, 8'd45, 32'h0);
        expect_out("R8 eop clear after gate", 1'b0, 1'b0, 4'd0, 8'd0);

        // R3 R8: one evaluation per packet, result holds across later beats, sop clears
        beat(ME, 1'b1, 1'b0, 8'd60, with_key(8'h33, 8'h01));
        expect_out("R3 sop beat is not key window", 1'b0, 1'b0, 4'd0, 8'd0);
        beat(ME, 1'b0, 1'b0, 8'd61, with_key(8'h22, 8'h02));
        expect_out("R7 duplicate key lowest index", 1'b1, 1'b0, 4'd6, 8'd61);
        for (int i = 0; i < 12; i++) begin
            beat(ME, 1'b0, 1'b0, 8'(70 + i), with_key(8'h11, 8'(i)));
            expect_out("R3 R8 hold, no second evaluation", 1'b1, 1'b0, 4'd6, 8'd61);
        end
        beat(ME, 1'b1, 1'b0, 8'd90, 32'h0);
        expect_out("R8 new sop clears", 1'b0, 1'b0, 4'd0, 8'd0);
        beat(ME, 1'b0, 1'b0, 8'd91, with_key(8'h44, 8'h03));
        expect_out("R6 miss after sop", 1'b0, 1'b1, 4'd0, 8'd91);
        // idle cycles with valid low keep the result
        repeat (3) @(posedge clk);
        #1;
        expect_out("R2 idle cycles hold", 1'b0, 1'b1, 4'd0, 8'd91);
        beat(ME, 1'b0, 1'b1, 8'd92, 32'h0);
        expect_out("R8 eop clears exception", 1'b0, 1'b0, 4'd0, 8'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule